// File: doc/BRIEF.md
# Calibration Record Loader

After reset, this block fetches a small calibration record from a byte-wide identification ROM. The ROM is reached through a plain request/address/data port with a fixed read latency. The block first confirms a four-character ASCII signature at the start of the record. It then skips the remaining header bytes, except for the checksum byte, which it keeps. Finally it rebuilds six signed 16-bit correction words: an offset and a gain for each of three output channels. Each correction is in quarter-LSB units.

The record holds 24 bytes and is read once, one byte at a time, in ascending byte order. Each correction word is stored as two bytes, high byte first. The words appear in the record as the three offsets (channel A, B, C) and then the three gains (A, B, C). When the last byte has been captured, the block raises a valid flag. If the signature is wrong, it stops reading at once, raises an error flag and leaves every correction output at zero.

The ROM port carries no back-pressure. Only one read is outstanding at a time, and the data returns exactly `RD_LAT` cycles after the request, so neither side ever stalls the other. For carriers that place ROM bytes at odd addresses of a 16-bit word bus, the bus address is also presented.

Top module: `calrec_loader`

## Requirements
- R1: While reset is held, `rom_rd`, `cal_valid` and `sig_err` are low, and all six correction outputs and `rec_crc` are zero.
- R2: After reset is released, the block holds `rom_rd` low for one cycle. It then issues reads of byte indices 0, 1, 2, ... in ascending order, one request per single-cycle `rom_rd` pulse. It samples `rom_data` at the `RD_LAT`-th rising edge after the request edge and issues the next request on the edge that follows. Consecutive requests are therefore exactly `RD_LAT`+1 cycles apart.
- R3: Whenever `rom_rd` is high, `rom_bus_addr` equals 2 × `rom_addr` + 1.
- R4: Bytes 0 to 3 must read 0x49, 0x50, 0x41, 0x43 ('I','P','A','C'). On the first mismatch, `sig_err` rises after the edge that samples the bad byte. No further read is issued, `cal_valid` never rises, and every correction output stays zero.
- R5: The correction words are assembled from bytes 12 to 23. Byte 12+2k is the high half and byte 13+2k is the low half of word k. Word 0 drives `off_a`, word 1 `off_b`, word 2 `off_c`, word 3 `gain_a`, word 4 `gain_b` and word 5 `gain_c`, and each is output as a signed two's-complement value.
- R6: Byte 11 (the checksum) is presented unmodified on `rec_crc`.
- R7: `cal_valid` rises after the edge that samples byte 23, which is edge number 2 + 23·(`RD_LAT`+1) + `RD_LAT` after reset release. Exactly 24 reads are issued, and no read follows.
- R8: Once raised, `cal_valid` or `sig_err` stays high until the next reset, the two are never high together, and the correction outputs hold their values.
- R9: Header bytes 4 to 10 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; a load starts when it is released |
| rom_rd | output | 1 | Single-cycle ROM read request |
| rom_addr | output | IDX_W | Raw byte index of the request |
| rom_bus_addr | output | IDX_W+1 | Odd word-bus address, 2·index+1 |
| rom_data | input | 8 | ROM byte, valid `RD_LAT` cycles after the request |
| off_a | output | 16 | Channel A offset correction, signed |
| off_b | output | 16 | Channel B offset correction, signed |
| off_c | output | 16 | Channel C offset correction, signed |
| gain_a | output | 16 | Channel A gain correction, signed |
| gain_b | output | 16 | Channel B gain correction, signed |
| gain_c | output | 16 | Channel C gain correction, signed |
| rec_crc | output | 8 | Stored checksum byte |
| cal_valid | output | 1 | All correction words captured |
| sig_err | output | 1 | Signature mismatch, load abandoned |

## Verification
The bench builds the block with `RD_LAT` = 3 instead of the default 2, so the wait counter runs through several states and the request spacing of four cycles is clearly separated from the back-to-back case. `IDX_W` stays at 5, which covers a 32-byte ROM, so the word-bus address reaches its widest value of 47 for byte 23. Together these make the exact valid edge (97 after release) and the error edges for mismatches at bytes 0, 2 and 3 precise, distinguishable targets. Correction words that include 0x8000, 0x7FFF and 0xFFFE exercise the signed extremes.

// File: rtl/calrec_pkg.sv
package calrec_pkg;

  localparam int unsigned SIG_LEN  = 4;
  localparam int unsigned HDR_LEN  = 12;
  localparam int unsigned CRC_IDX  = 11;
  localparam int unsigned N_CH     = 3;
  localparam int unsigned N_WORD   = 2 * N_CH;
  localparam int unsigned REC_LEN  = HDR_LEN + 2 * N_WORD;
  localparam int unsigned WORD_W   = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT,
    ST_DONE,
    ST_FAIL
  } seq_st_t;

  function automatic logic [7:0] sig_char(input logic [1:0] pos);
    case (pos)
      2'd0:    sig_char = 8'h49;
      2'd1:    sig_char = 8'h50;
      2'd2:    sig_char = 8'h41;
      default: sig_char = 8'h43;
    endcase
  endfunction

endpackage

// File: rtl/calrec_seq.sv
module calrec_seq
  import calrec_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned RD_LAT = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sig_bad,
  output logic             rd_req,
  output logic             cap,
  output logic [IDX_W-1:0] idx,
  output logic             done_ok,
  output logic             done_bad
);

  localparam int unsigned CNT_W = (RD_LAT > 1) ? $clog2(RD_LAT) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RD_LAT - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(REC_LEN - 1);

  seq_st_t          st;
  logic [CNT_W-1:0] cnt;

  assign rd_req = (st == ST_ISSUE);
  assign cap    = (st == ST_WAIT) && (cnt == CNT_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      idx      <= '0;
      done_ok  <= 1'b0;
      done_bad <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: st <= ST_ISSUE;
        ST_ISSUE: begin
          st  <= ST_WAIT;
          cnt <= '0;
        end
        ST_WAIT: begin
          if (cap) begin
            if (sig_bad) begin
              st       <= ST_FAIL;
              done_bad <= 1'b1;
            end else if (idx == IDX_LAST) begin
              st      <= ST_DONE;
              done_ok <= 1'b1;
            end else begin
              idx <= idx + 1'b1;
              st  <= ST_ISSUE;
            end
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: st <= st;
      endcase
    end
  end

endmodule

// File: rtl/calrec_sigchk.sv
module calrec_sigchk
  import calrec_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             cap,
  input  logic [IDX_W-1:0] idx,
  input  logic [7:0]       data,
  output logic             sig_bad
);

  logic in_sig;

  always_comb begin
    in_sig  = (idx < IDX_W'(SIG_LEN));
    sig_bad = cap && in_sig && (data != sig_char(idx[1:0]));
  end

endmodule

// File: rtl/calrec_words.sv
module calrec_words
  import calrec_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cap,
  input  logic [IDX_W-1:0]              idx,
  input  logic [7:0]                    data,
  output logic [N_WORD-1:0][WORD_W-1:0] words,
  output logic [7:0]                    crc
);

  for (genvar w = 0; w < N_WORD; w++) begin : g_word
    localparam logic [IDX_W-1:0] HI_IDX = IDX_W'(HDR_LEN + 2 * w);
    localparam logic [IDX_W-1:0] LO_IDX = IDX_W'(HDR_LEN + 2 * w + 1);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        words[w] <= '0;
      end else if (cap && idx == HI_IDX) begin
        words[w][15:8] <= data;
      end else if (cap && idx == LO_IDX) begin
        words[w][7:0] <= data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crc <= '0;
    end else if (cap && idx == IDX_W'(CRC_IDX)) begin
      crc <= data;
    end
  end

endmodule

// File: rtl/calrec_loader.sv
module calrec_loader
  import calrec_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned RD_LAT = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  output logic               rom_rd,
  output logic [IDX_W-1:0]   rom_addr,
  output logic [IDX_W:0]     rom_bus_addr,
  input  logic [7:0]         rom_data,
  output logic signed [15:0] off_a,
  output logic signed [15:0] off_b,
  output logic signed [15:0] off_c,
  output logic signed [15:0] gain_a,
  output logic signed [15:0] gain_b,
  output logic signed [15:0] gain_c,
  output logic [7:0]         rec_crc,
  output logic               cal_valid,
  output logic               sig_err
);

  logic                          cap;
  logic                          sig_bad;
  logic [IDX_W-1:0]              idx;
  logic [N_WORD-1:0][WORD_W-1:0] words;

  calrec_seq #(.IDX_W(IDX_W), .RD_LAT(RD_LAT)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .sig_bad  (sig_bad),
    .rd_req   (rom_rd),
    .cap      (cap),
    .idx      (idx),
    .done_ok  (cal_valid),
    .done_bad (sig_err)
  );

  calrec_sigchk #(.IDX_W(IDX_W)) u_sig (
    .cap     (cap),
    .idx     (idx),
    .data    (rom_data),
    .sig_bad (sig_bad)
  );

  calrec_words #(.IDX_W(IDX_W)) u_words (
    .clk   (clk),
    .rst_n (rst_n),
    .cap   (cap),
    .idx   (idx),
    .data  (rom_data),
    .words (words),
    .crc   (rec_crc)
  );

  assign rom_addr     = idx;
  assign rom_bus_addr = {idx, 1'b1};

  assign off_a  = words[0];
  assign off_b  = words[1];
  assign off_c  = words[2];
  assign gain_a = words[3];
  assign gain_b = words[4];
  assign gain_c = words[5];

endmodule

// File: rtl/calrec_loader_chk.sv
module calrec_loader_chk #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned RD_LAT = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rom_rd,
  input logic [IDX_W-1:0] rom_addr,
  input logic [15:0]      off_a,
  input logic [15:0]      off_b,
  input logic [15:0]      off_c,
  input logic [15:0]      gain_a,
  input logic [15:0]      gain_b,
  input logic [15:0]      gain_c,
  input logic             cal_valid,
  input logic             sig_err
);

  logic [15:0] gap;
  logic        seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (rom_rd) begin
      gap  <= 16'd1;
      seen <= 1'b1;
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 16'd1;
    end
  end

  // R2: request is a one-cycle pulse and its address holds afterwards
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> !rom_rd);
  a_r2_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rom_rd |=> $stable(rom_addr));
  // R2: requests spaced by exactly RD_LAT+1 cycles
  a_r2_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && seen) |-> (gap == 16'(RD_LAT + 1)));
  // R4: a failed signature keeps outputs zero and stops reads
  a_r4_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> (off_a == 16'd0 && off_b == 16'd0 && off_c == 16'd0 &&
                 gain_a == 16'd0 && gain_b == 16'd0 && gain_c == 16'd0));
  a_r4_err_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |-> !rom_rd);
  // R7: no read after the record is complete
  a_r7_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |-> !rom_rd);
  // R8: flags sticky, exclusive, outputs frozen
  a_r8_valid_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    cal_valid |=> (cal_valid && $stable(off_a) && $stable(off_b) && $stable(off_c) &&
                   $stable(gain_a) && $stable(gain_b) && $stable(gain_c)));
  a_r8_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    sig_err |=> sig_err);
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(cal_valid && sig_err));

endmodule

bind calrec_loader calrec_loader_chk #(.IDX_W(IDX_W), .RD_LAT(RD_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rom_rd    (rom_rd),
  .rom_addr  (rom_addr),
  .off_a     (off_a),
  .off_b     (off_b),
  .off_c     (off_c),
  .gain_a    (gain_a),
  .gain_b    (gain_b),
  .gain_c    (gain_c),
  .cal_valid (cal_valid),
  .sig_err   (sig_err)
);

// File: tb/calrec_loader_bench.sv
`timescale 1ns/1ps
module calrec_loader_bench;

  localparam int unsigned IDX_W = 5;
  localparam int unsigned RDL   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rom_rd;
  logic [IDX_W-1:0] rom_addr;
  logic [IDX_W:0]   rom_bus_addr;
  logic [7:0]  rom_data;
  logic signed [15:0] off_a, off_b, off_c, gain_a, gain_b, gain_c;
  logic [7:0]  rec_crc;
  logic        cal_valid, sig_err;

  int unsigned n_run  = 0;
  int unsigned n_fail = 0;
  bit          finished = 1'b0;

  always #5 clk = ~clk;

  calrec_loader #(.IDX_W(IDX_W), .RD_LAT(RDL)) u_calrec_loader (
    .clk(clk), .rst_n(rst_n), .rom_rd(rom_rd), .rom_addr(rom_addr),
    .rom_bus_addr(rom_bus_addr), .rom_data(rom_data),
    .off_a(off_a), .off_b(off_b), .off_c(off_c),
    .gain_a(gain_a), .gain_b(gain_b), .gain_c(gain_c),
    .rec_crc(rec_crc), .cal_valid(cal_valid), .sig_err(sig_err)
  );

  // ROM model with fixed latency
  logic [7:0] rom [32];
  logic [7:0] pipe [RDL];
  always @(posedge clk) begin
    pipe[0] <= rom_rd ? rom[rom_addr] : 8'h00;
    for (int i = 1; i < RDL; i++) pipe[i] <= pipe[i-1];
  end
  assign rom_data = pipe[RDL-1];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // edge counter since reset release
  int unsigned cyc;
  always @(posedge clk) if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  // read monitor: order and bus address
  int unsigned nxt, nreads;
  always @(negedge clk) begin
    if (!rst_n) begin
      nxt = 0; nreads = 0;
    end else if (rom_rd) begin
      chk(rom_addr == nxt[IDX_W-1:0], "R2 read order", rom_addr, nxt);
      chk(rom_bus_addr == (2*nxt+1), "R3 bus address", rom_bus_addr, 2*nxt+1);
      nxt++; nreads++;
    end
  end

  // scoreboard
  logic [15:0] exp_q[$];
  bit prev_valid = 1'b0;
  always @(negedge clk) begin
    if (cal_valid && !prev_valid) begin
      logic [15:0] act [7];
      act = '{off_a, off_b, off_c, gain_a, gain_b, gain_c, {8'h00, rec_crc}};
      for (int k = 0; k < 7; k++) begin
        logic [15:0] e;
        if (exp_q.size() == 0) begin
          chk(1'b0, "R5 scoreboard empty", act[k], 0);
        end else begin
          e = exp_q.pop_front();
          chk(act[k] == e, (k == 6) ? "R6 checksum" : "R5 word", act[k], e);
        end
      end
    end
    prev_valid = cal_valid;
  end

  // driver: fills the ROM and pushes expectations
  task automatic load_rom(input logic [7:0] sig [4], input logic [7:0] hdr_fill,
                          input logic [15:0] w [6], input logic [7:0] crc, input bit push);
    for (int i = 0; i < 32; i++) rom[i] = 8'hEE;
    for (int i = 0; i < 4; i++) rom[i] = sig[i];
    for (int i = 4; i < 11; i++) rom[i] = hdr_fill ^ 8'(i);
    rom[11] = crc;
    for (int k = 0; k < 6; k++) begin
      rom[12+2*k] = w[k][15:8];
      rom[13+2*k] = w[k][7:0];
      if (push) exp_q.push_back(w[k]);
    end
    if (push) exp_q.push_back({8'h00, crc});
  endtask

  task automatic run_case(input bit exp_ok, input int unsigned exp_edge, input int unsigned exp_reads);
    int unsigned guard;
    int unsigned reads_at_end;
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!rom_rd && !cal_valid && !sig_err, "R1 flags in reset", {rom_rd, cal_valid, sig_err}, 0);
    chk(off_a == 0 && off_b == 0 && off_c == 0 && gain_a == 0 && gain_b == 0 &&
        gain_c == 0 && rec_crc == 0, "R1 outputs in reset", off_a, 0);
    rst_n = 1'b1;
    guard = 0;
    while (!cal_valid && !sig_err && guard < 2000) begin
      @(negedge clk); guard++;
    end
    if (exp_ok) begin
      chk(cal_valid && !sig_err, "R7 valid raised", {cal_valid, sig_err}, 2'b10);
      chk(cyc == exp_edge, "R7 valid edge", cyc, exp_edge);
    end else begin
      chk(sig_err && !cal_valid, "R4 error raised", {cal_valid, sig_err}, 2'b01);
      chk(cyc == exp_edge, "R4 error edge", cyc, exp_edge);
      chk(off_a == 0 && off_b == 0 && off_c == 0 && gain_a == 0 && gain_b == 0 &&
          gain_c == 0, "R4 outputs zero", off_a, 0);
    end
    chk(nreads == exp_reads, exp_ok ? "R7 read count" : "R4 read count", nreads, exp_reads);
    reads_at_end = nreads;
    repeat (12) @(negedge clk);
    chk(nreads == reads_at_end, "R8 no reads after end", nreads, reads_at_end);
    chk(cal_valid == exp_ok && sig_err == !exp_ok, "R8 flags sticky", {cal_valid, sig_err}, {exp_ok, !exp_ok});
  endtask

  localparam int unsigned OK_EDGE = 2 + 23*(RDL+1) + RDL;

  initial begin
    logic [7:0]  good [4] = '{8'h49, 8'h50, 8'h41, 8'h43};
    logic [7:0]  bad  [4];
    logic [15:0] w1 [6] = '{16'h1234, 16'hFFFE, 16'h8000, 16'h7FFF, 16'h0001, 16'hFF00};
    logic [15:0] w2 [6] = '{16'hFF00, 16'h0001, 16'h7FFF, 16'h8000, 16'hFFFE, 16'h1234};
    logic [15:0] w3 [6] = '{16'h0000, 16'hFFFF, 16'h00FF, 16'hFF00, 16'hA55A, 16'h5AA5};

    // R5 R6: main load
    load_rom(good, 8'h20, w1, 8'h5A, 1'b1);
    run_case(1'b1, OK_EDGE, 24);
    // R9: different header bytes, different words
    load_rom(good, 8'hC3, w2, 8'hA5, 1'b1);
    run_case(1'b1, OK_EDGE, 24);
    // R9: header filled so bytes 4..10 differ again
    load_rom(good, 8'h00, w3, 8'h00, 1'b1);
    run_case(1'b1, OK_EDGE, 24);
    // R4: mismatch at byte 2
    bad = good; bad[2] = 8'h58;
    load_rom(bad, 8'h20, w1, 8'h11, 1'b0);
    run_case(1'b0, 2 + 2*(RDL+1) + RDL, 3);
    // R4: mismatch at byte 0
    bad = good; bad[0] = 8'h69;
    load_rom(bad, 8'h20, w1, 8'h11, 1'b0);
    run_case(1'b0, 2 + RDL, 1);
    // R4: mismatch at byte 3
    bad = good; bad[3] = 8'h44;
    load_rom(bad, 8'h20, w2, 8'h11, 1'b0);
    run_case(1'b0, 2 + 3*(RDL+1) + RDL, 4);

    chk(exp_q.size() == 0, "R5 scoreboard drained", exp_q.size(), 0);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      finished = 1'b1;
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule